// File: doc/BRIEF.md
# Bus Region Select and Transfer Acknowledge

This block decodes an asynchronous microprocessor bus cycle into chip selects for three regions: a read-only program store, a read/write data store and a byte-wide parallel port. It qualifies the decode with the address strobe, the cycle's function code and the read/write line. The two data strobes pick which byte lanes of the 16-bit bus a memory region drives or captures. The port sits on the low lane and exposes two register-select address bits.

The transfer acknowledge is registered. Each region has its own wait-state count, set by a parameter, so a slow device holds the processor off for a fixed number of clocks. If the access targets no mapped region, or its function code does not qualify it, the acknowledge is never given and the cycle stalls until the strobe is withdrawn. Selects and enables are combinational from the bus inputs. The acknowledge counter is the only state in the block.

Top module: `bus_select_ack`

## Requirements
- R1: The three decode bits `addr_dec_i` select the program store for 000, the data store for 001 and the port for 110. The other five values select nothing.
- R2: While `as_n` is high, every chip select, output enable and write enable is high (inactive).
- R3: Lane vectors use bit 1 for data bits 8-15 and bit 0 for data bits 0-7. `uds_n` low enables bit 1, `lds_n` low enables bit 0, and both low give a word access.
- R4: The program store and the data store respond only to function codes 001, 010, 101 and 110. The port responds only to 001 and 101 (data accesses). Any other code selects nothing.
- R5: The program store lanes and its output enables assert only when `rw` is 1, and `rom_oe_n` always equals `rom_cs_n`. A write to that region is acknowledged, but the store stays deselected.
- R6: In the data store, `ram_we_n` lanes assert only when `rw` is 0, and `ram_oe_n` asserts only when `rw` is 1.
- R7: The port is selected only while `lds_n` is low. `port_reg_o` equals `addr_reg_i`, `port_oe_n` asserts on reads and `port_we_n` asserts on writes.
- R8: Count the rising edges at which `as_n` is sampled low, starting from 0. For a qualified access, `dtack_n` goes low after edge number W, where W is 0 to 7 and is that region's wait count.
- R9: `dtack_n` is high after the first rising edge at which `as_n` is sampled high. A later strobe assertion restarts the count from 0.
- R10: An unmapped or unqualified access never drives `dtack_n` low.
- R11: While `rst_n` is sampled low, `dtack_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_dec_i | input | 3 | Region decode address bits |
| addr_reg_i | input | 2 | Port register address bits |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| fc_i | input | 3 | Cycle function code |
| rom_cs_n | output | 2 | Program store lane selects |
| rom_oe_n | output | 2 | Program store lane output enables |
| ram_cs_n | output | 2 | Data store lane selects |
| ram_oe_n | output | 1 | Data store output enable |
| ram_we_n | output | 2 | Data store lane write enables |
| port_cs_n | output | 1 | Port select |
| port_oe_n | output | 1 | Port read enable |
| port_we_n | output | 1 | Port write enable |
| port_reg_o | output | 2 | Port register select |
| dtack_n | output | 1 | Transfer acknowledge, active low |

## Verification
The bench builds the block with a wait count of 0 for the program store, 3 for the data store and 7 for the port. This covers both ends of the counter and one middle value. With zero waits, the acknowledge must appear on the very first sampling edge. With seven, the counter must not stop short of saturation. Strobe hold times of 1 to 10 clocks fall both short of and beyond each wait count, so some cycles end before their acknowledge and some end after it.

// File: rtl/bsa_pkg.sv
// Package: shared region codes and function-code qualification.
// Assumes a 3-bit decode field and a 3-bit function code.
package bsa_pkg;
    localparam int DEC_W    = 3;
    localparam int FC_W     = 3;
    localparam int N_SEL    = 1 << DEC_W;
    localparam logic [DEC_W-1:0] CODE_ROM  = 3'b000;
    localparam logic [DEC_W-1:0] CODE_RAM  = 3'b001;
    localparam logic [DEC_W-1:0] CODE_PORT = 3'b110;

    // Program or data cycle in either privilege level
    function automatic logic fc_mem_ok(input logic [FC_W-1:0] fc);
        return (fc == 3'b001) || (fc == 3'b010) || (fc == 3'b101) || (fc == 3'b110);
    endfunction

    // Data cycle in either privilege level
    function automatic logic fc_data_ok(input logic [FC_W-1:0] fc);
        return (fc == 3'b001) || (fc == 3'b101);
    endfunction
endpackage

// File: rtl/bsa_region_decode.sv
// Region decoder: 3-to-8 active-low one-hot select.
// Assumes en_n qualifies the field; with en_n high all outputs stay high.
module bsa_region_decode #(
    parameter int W = 3,
    localparam int N = 1 << W
) (
    input  logic         en_n,
    input  logic [W-1:0] code_i,
    output logic [N-1:0] sel_n
);
    for (genvar g = 0; g < N; g++) begin : g_sel
        // one output per code value
        assign sel_n[g] = en_n | (code_i != W'(g));
    end
endmodule

// File: rtl/bsa_lane_enable.sv
// Byte-lane gate: turns a region select and the two data strobes
// into active-low lane enables (bit 1 = upper lane, bit 0 = lower lane).
module bsa_lane_enable (
    input  logic       sel_i,
    input  logic       uds_n,
    input  logic       lds_n,
    output logic [1:0] lane_n
);
    // lane asserts when region selected and its strobe low
    always_comb begin
        lane_n[1] = ~(sel_i & ~uds_n);
        lane_n[0] = ~(sel_i & ~lds_n);
    end
endmodule

// File: rtl/bsa_ack_timer.sv
// Acknowledge timer: counts clocks from the first edge the strobe is
// seen low and drives the registered acknowledge once the count
// reaches the wait value. Assumes hit_i and ws_i are stable while the
// strobe is held.
module bsa_ack_timer #(
    parameter int WS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            as_n,
    input  logic            hit_i,
    input  logic [WS_W-1:0] ws_i,
    output logic            dtack_n
);
    localparam logic [WS_W-1:0] CNT_MAX = '1;

    logic            busy;
    logic [WS_W-1:0] cnt;

    // track strobe cycle, count wait clocks, register acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            dtack_n <= 1'b1;
        end else if (as_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            dtack_n <= 1'b1;
        end else if (!busy) begin
            busy    <= 1'b1;
            cnt     <= WS_W'(1);
            dtack_n <= ~(hit_i && (ws_i == '0));
        end else begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            dtack_n <= ~(hit_i && (cnt >= ws_i));
        end
    end

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> dtack_n);

    // R10
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> $past(hit_i));

    // R8
    zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && !busy && hit_i && ws_i == '0) |=> !dtack_n);
endmodule

// File: rtl/bus_select_ack.sv
// Top: bus region select and transfer acknowledge.
// Selects and enables are combinational from the bus; acknowledge is
// registered with a per-region wait count. Assumes bus inputs are
// stable while as_n is low.
module bus_select_ack #(
    parameter int WS_W      = 3,
    parameter int ROM_WAIT  = 0,
    parameter int RAM_WAIT  = 3,
    parameter int PORT_WAIT = 7,
    parameter int REG_W     = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [bsa_pkg::DEC_W-1:0] addr_dec_i,
    input  logic [REG_W:1]          addr_reg_i,
    input  logic                    as_n,
    input  logic                    rw,
    input  logic                    uds_n,
    input  logic                    lds_n,
    input  logic [bsa_pkg::FC_W-1:0] fc_i,
    output logic [1:0]              rom_cs_n,
    output logic [1:0]              rom_oe_n,
    output logic [1:0]              ram_cs_n,
    output logic                    ram_oe_n,
    output logic [1:0]              ram_we_n,
    output logic                    port_cs_n,
    output logic                    port_oe_n,
    output logic                    port_we_n,
    output logic [REG_W:1]          port_reg_o,
    output logic                    dtack_n
);
    import bsa_pkg::*;

    localparam logic [WS_W-1:0] WS_ROM  = WS_W'(ROM_WAIT);
    localparam logic [WS_W-1:0] WS_RAM  = WS_W'(RAM_WAIT);
    localparam logic [WS_W-1:0] WS_PORT = WS_W'(PORT_WAIT);

    logic [N_SEL-1:0] dec_n;
    logic             rom_region, ram_sel, port_sel, rom_rd, hit;
    logic [WS_W-1:0]  ws;
    logic [1:0]       ram_lane_n;

    bsa_region_decode #(.W(DEC_W)) u_dec (
        .en_n   (as_n),
        .code_i (addr_dec_i),
        .sel_n  (dec_n)
    );

    // qualify each region with function code, direction and lane
    always_comb begin
        rom_region = ~dec_n[CODE_ROM]  & fc_mem_ok(fc_i);
        rom_rd     = rom_region & rw;
        ram_sel    = ~dec_n[CODE_RAM]  & fc_mem_ok(fc_i);
        port_sel   = ~dec_n[CODE_PORT] & fc_data_ok(fc_i) & ~lds_n;
        hit        = rom_region | ram_sel | port_sel;
    end

    // pick the wait count of the region being accessed
    always_comb begin
        if (rom_region)   ws = WS_ROM;
        else if (ram_sel) ws = WS_RAM;
        else              ws = WS_PORT;
    end

    bsa_lane_enable u_rom_lane (
        .sel_i  (rom_rd),
        .uds_n  (uds_n),
        .lds_n  (lds_n),
        .lane_n (rom_cs_n)
    );

    bsa_lane_enable u_ram_lane (
        .sel_i  (ram_sel),
        .uds_n  (uds_n),
        .lds_n  (lds_n),
        .lane_n (ram_lane_n)
    );

    // derive direction enables for data store and port
    always_comb begin
        rom_oe_n   = rom_cs_n;
        ram_cs_n   = ram_lane_n;
        ram_oe_n   = ~(ram_sel & rw);
        ram_we_n   = ram_lane_n | {2{rw}};
        port_cs_n  = ~port_sel;
        port_oe_n  = ~(port_sel & rw);
        port_we_n  = ~(port_sel & ~rw);
        port_reg_o = addr_reg_i;
    end

    bsa_ack_timer #(.WS_W(WS_W)) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .as_n    (as_n),
        .hit_i   (hit),
        .ws_i    (ws),
        .dtack_n (dtack_n)
    );

    // R1
    region_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~&rom_cs_n, ~&ram_cs_n, ~port_cs_n}));

    // R2
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> (&rom_cs_n && &ram_cs_n && ram_oe_n && port_cs_n));

    // R5
    rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rw |-> &rom_cs_n);

    // R6
    ram_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&ram_we_n) |-> ram_oe_n);

    // R7
    port_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_cs_n |-> !lds_n);
endmodule

// File: tb/bus_select_ack_tb.sv
module bus_select_ack_tb;
    localparam int ROM_W = 0, RAM_W = 3, PORT_W = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] addr_dec = 3'd0;
    logic [2:1] addr_reg = 2'd0;
    logic as_n = 1'b1, rw = 1'b1, uds_n = 1'b1, lds_n = 1'b1;
    logic [2:0] fc = 3'b001;
    logic [1:0] rom_cs_n, rom_oe_n, ram_cs_n, ram_we_n;
    logic ram_oe_n, port_cs_n, port_oe_n, port_we_n, dtack_n;
    logic [2:1] port_reg;
    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    bus_select_ack #(.ROM_WAIT(ROM_W), .RAM_WAIT(RAM_W), .PORT_WAIT(PORT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_dec_i(addr_dec), .addr_reg_i(addr_reg),
        .as_n(as_n), .rw(rw), .uds_n(uds_n), .lds_n(lds_n), .fc_i(fc),
        .rom_cs_n(rom_cs_n), .rom_oe_n(rom_oe_n), .ram_cs_n(ram_cs_n),
        .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .port_cs_n(port_cs_n),
        .port_oe_n(port_oe_n), .port_we_n(port_we_n), .port_reg_o(port_reg),
        .dtack_n(dtack_n));

    function automatic logic mem_fc(input logic [2:0] f);
        return f == 3'b001 || f == 3'b010 || f == 3'b101 || f == 3'b110;
    endfunction
    function automatic logic dat_fc(input logic [2:0] f);
        return f == 3'b001 || f == 3'b101;
    endfunction

    // expected outputs packed: rom_cs,rom_oe,ram_cs,ram_oe,ram_we,port_cs,port_oe,port_we,reg
    function automatic logic [13:0] exp_out(input logic a, input logic [2:0] d,
            input logic [2:1] r, input logic w, input logic u, input logic l, input logic [2:0] f);
        logic rom, ram, prt;
        logic [1:0] lanes, rc, mc, mw;
        rom = !a && d == 3'b000 && mem_fc(f) && w;
        ram = !a && d == 3'b001 && mem_fc(f);
        prt = !a && d == 3'b110 && dat_fc(f) && !l;
        lanes = {!u, !l};
        rc = rom ? ~lanes : 2'b11;
        mc = ram ? ~lanes : 2'b11;
        mw = (ram && !w) ? ~lanes : 2'b11;
        return {rc, rc, mc, !(ram && w), mw, !prt, !(prt && w), !(prt && !w), r};
    endfunction

    function automatic logic exp_hit(input logic [2:0] d, input logic l, input logic [2:0] f);
        return (d == 3'b000 && mem_fc(f)) || (d == 3'b001 && mem_fc(f)) ||
               (d == 3'b110 && dat_fc(f) && !l);
    endfunction

    function automatic int exp_ws(input logic [2:0] d);
        return d == 3'b000 ? ROM_W : (d == 3'b001 ? RAM_W : PORT_W);
    endfunction

    function automatic logic [13:0] act_out();
        return {rom_cs_n, rom_oe_n, ram_cs_n, ram_oe_n, ram_we_n,
                port_cs_n, port_oe_n, port_we_n, port_reg};
    endfunction

    task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one full bus cycle: assert strobe, hold, release
    task automatic access(input logic [2:0] d, input logic [2:1] r, input logic w,
            input logic u, input logic l, input logic [2:0] f, input int hold);
        logic h;
        int ws;
        @(negedge clk);
        addr_dec = d; addr_reg = r; rw = w; uds_n = u; lds_n = l; fc = f; as_n = 1'b0;
        #1;
        check(act_out() == exp_out(1'b0, d, r, w, u, l, f),
              "R1 R3 R4 R5 R6 R7 selects", 16'(act_out()), 16'(exp_out(1'b0, d, r, w, u, l, f)));
        h = exp_hit(d, l, f);
        ws = exp_ws(d);
        for (int j = 0; j < hold; j++) begin
            @(posedge clk); #2;
            check(dtack_n == !(h && j >= ws), h ? "R8 wait count" : "R10 no ack",
                  16'(dtack_n), 16'(!(h && j >= ws)));
        end
        @(negedge clk);
        as_n = 1'b1;
        #1;
        check(act_out() == exp_out(1'b1, d, r, w, u, l, f), "R2 strobe idle",
              16'(act_out()), 16'(exp_out(1'b1, d, r, w, u, l, f)));
        @(posedge clk); #2;
        check(dtack_n == 1'b1, "R9 release", 16'(dtack_n), 16'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        as_n = 1'b0; addr_dec = 3'b001;
        repeat (3) @(posedge clk);
        #2;
        check(dtack_n == 1'b1, "R11 reset", 16'(dtack_n), 16'd1);
        @(negedge clk);
        as_n = 1'b1; rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed corners
        access(3'b000, 2'd0, 1'b1, 1'b0, 1'b0, 3'b010, 3);   // R8 zero-wait program read
        access(3'b000, 2'd0, 1'b0, 1'b0, 1'b0, 3'b001, 3);   // R5 write to program store
        access(3'b001, 2'd1, 1'b0, 1'b1, 1'b0, 3'b001, 6);   // R6 low-lane write
        access(3'b001, 2'd1, 1'b1, 1'b0, 1'b1, 3'b101, 2);   // R9 release before ack
        access(3'b001, 2'd1, 1'b1, 1'b0, 1'b1, 3'b101, 5);   // R9 fresh count
        access(3'b110, 2'd3, 1'b0, 1'b1, 1'b0, 3'b001, 10);  // R7 R8 port, full wait
        access(3'b110, 2'd2, 1'b1, 1'b0, 1'b1, 3'b001, 9);   // R7 upper lane only: stall
        access(3'b110, 2'd2, 1'b1, 1'b1, 1'b0, 3'b010, 9);   // R4 program fetch to port
        access(3'b011, 2'd0, 1'b1, 1'b0, 1'b0, 3'b001, 8);   // R10 unmapped
        access(3'b000, 2'd0, 1'b1, 1'b0, 1'b0, 3'b111, 4);   // R4 interrupt-ack code

        // constrained random
        for (int i = 0; i < 400; i++) begin
            int k;
            logic [2:0] d;
            k = int'($urandom % 10);
            d = (k < 3) ? 3'b000 : (k < 6) ? 3'b001 : (k < 8) ? 3'b110 : 3'($urandom);
            access(d, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   ($urandom % 4 != 0) ? 3'b001 + 3'($urandom % 2) : 3'($urandom),
                   1 + int'($urandom % 10));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule